// File: doc/BRIEF.md
# Byte-Stream Hamming ECC Generator

This block computes a single-error-correcting, double-error-detecting parity code over a stream of bytes as they cross a byte-wide data interface. No second pass over the data is needed. Each accepted byte adds to two sets of running parities. Line parity is folded by the bits of the byte's index within the page. Column parity is folded by the bit position inside the byte. When the last byte of a page is accepted, the finished 24-bit code word is presented together with a one-cycle valid pulse.

A mode input selects the page size. In narrow mode, each 256-byte page gets its own code, so a 512-byte stretch yields two codes, tagged first half and second half. In wide mode, one code covers all 512 bytes. A synchronous clear throws away a partly accumulated page. A separate compare port takes a stored code and a recomputed code for the same data, and classifies the difference. For a correctable single-bit error it reports the byte index and the bit position. Only byte-wide traffic may be routed to this block.

Top module: `ecc_stream_gen`

## Requirements
- R1: After reset, `code_valid` and `cmp_done` are 0 and `code` is all ones. A pulse on `clr` discards the bytes of the current page and restarts the byte count at zero.
- R2: With `mode_wide` = 0, a `code_valid` pulse follows the 256th and the 512th accepted byte. Each code covers only its own 256 bytes, and code bits 17:16 are both 1.
- R3: With `mode_wide` = 1, a single `code_valid` pulse follows the 512th accepted byte, and its code covers all 512 bytes.
- R4: Code bit 2k is the even parity of all data bits in bytes whose page index has bit k clear. Bit 2k+1 covers bytes whose index has bit k set. k runs 0..7 in narrow mode and 0..8 in wide mode.
- R5: Code bit 18+2j is the even parity of data bits at positions whose bit j is clear. Bit 19+2j covers positions whose bit j is set, for j = 0..2 over every byte of the page.
- R6: A byte presented while `in_valid` is 0 has no effect on any code.
- R7: A `cmp_req` yields `cmp_done` one cycle later. If stored and computed codes are equal, `cmp_class` is 0 (no error).
- R8: If every active even/odd pair of the XOR syndrome differs, and the inactive narrow-mode pair at bits 17:16 is zero, `cmp_class` is 1 (correctable). `cmp_byte` is then the odd bits of the line pairs and `cmp_bit` is the odd bits of the column pairs. For every other class, both fields are 0.
- R9: A syndrome with exactly one bit set gives `cmp_class` 2 (error in the code itself).
- R10: Any other nonzero syndrome gives `cmp_class` 3 (uncorrectable).
- R11: `code_valid` is high for exactly one cycle, and `code` holds its value between pulses.
- R12: `code_half` is 0 for the first narrow page and 1 for the second, and is always 0 in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Discard the current page and restart the count |
| mode_wide | input | 1 | 1: one code per 512 bytes; 0: one code per 256 bytes |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_data | input | 8 | Stream byte |
| code_valid | output | 1 | One-cycle pulse: `code` is fresh |
| code_half | output | 1 | Which 256-byte half the narrow code belongs to |
| code | output | 24 | Finished code word |
| cmp_req | input | 1 | Start a classification |
| cmp_wide | input | 1 | Codes being compared are wide-mode codes |
| cmp_stored | input | 24 | Code read back with the data |
| cmp_calc | input | 24 | Code recomputed over the data |
| cmp_done | output | 1 | Classification result is valid |
| cmp_class | output | 2 | 0 none, 1 correctable, 2 code error, 3 uncorrectable |
| cmp_byte | output | 9 | Byte index of a correctable error |
| cmp_bit | output | 3 | Bit position of a correctable error |

## Verification
The hardest case to reach is a correctable syndrome that names an exact byte and bit. To get there, a full page has to go through the stream with one bit flipped, and the clean code has to be paired with the corrupted one. The bench builds each page in a local array and streams it, idle bubbles included. It then flips chosen bits at the page edges (byte 0, byte 255, byte 511) as well as in the middle. The stored and recomputed code pairs it builds this way drive every compare class, in both page sizes.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int BYTE_W     = 8;
    localparam int LINE_PAIRS = 9;
    localparam int COL_PAIRS  = 3;
    localparam int PAIRS      = LINE_PAIRS + COL_PAIRS;
    localparam int CODE_W     = 2 * PAIRS;
    localparam int IDX_W      = LINE_PAIRS;
    localparam int COL_BASE   = 2 * LINE_PAIRS;
    localparam int PAD_PAIR   = LINE_PAIRS - 1;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_FIXABLE = 2'd1,
        ERR_IN_CODE = 2'd2,
        ERR_FATAL   = 2'd3
    } err_class_t;

    typedef struct packed {
        logic [LINE_PAIRS-1:0] odd;
        logic [LINE_PAIRS-1:0] even;
    } line_par_t;

    typedef struct packed {
        logic [COL_PAIRS-1:0] odd;
        logic [COL_PAIRS-1:0] even;
    } col_par_t;

    typedef struct packed {
        err_class_t           cls;
        logic [IDX_W-1:0]     byte_idx;
        logic [COL_PAIRS-1:0] bit_pos;
    } cmp_result_t;

    // Column contribution of a single byte.
    function automatic col_par_t col_contrib(input logic [BYTE_W-1:0] d);
        col_par_t c;
        c = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            for (int j = 0; j < COL_PAIRS; j++) begin
                if (b[j]) c.odd[j]  = c.odd[j]  ^ d[b];
                else      c.even[j] = c.even[j] ^ d[b];
            end
        end
        return c;
    endfunction

    // Pair k occupies bits [2k+1:2k]; the narrow mode pads the top line pair.
    function automatic logic [CODE_W-1:0] pack_code(input line_par_t lp,
                                                    input col_par_t  cp,
                                                    input logic      wide);
        logic [CODE_W-1:0] c;
        c = '1;
        for (int k = 0; k < LINE_PAIRS; k++) begin
            if (wide || k != PAD_PAIR) begin
                c[2*k]   = lp.even[k];
                c[2*k+1] = lp.odd[k];
            end
        end
        for (int j = 0; j < COL_PAIRS; j++) begin
            c[COL_BASE+2*j]   = cp.even[j];
            c[COL_BASE+2*j+1] = cp.odd[j];
        end
        return c;
    endfunction

    function automatic cmp_result_t classify(input logic [CODE_W-1:0] syn,
                                             input logic              wide);
        cmp_result_t r;
        logic        all_split;
        r = '{cls: ERR_NONE, byte_idx: '0, bit_pos: '0};
        all_split = 1'b1;
        for (int k = 0; k < PAIRS; k++) begin
            if (wide || k != PAD_PAIR)
                all_split = all_split & (syn[2*k] ^ syn[2*k+1]);
            else
                all_split = all_split & ~(syn[2*k] | syn[2*k+1]);
        end
        if (syn == '0) begin
            r.cls = ERR_NONE;
        end else if ($countones(syn) == 1) begin
            r.cls = ERR_IN_CODE;
        end else if (all_split) begin
            r.cls = ERR_FIXABLE;
            for (int k = 0; k < LINE_PAIRS; k++)
                r.byte_idx[k] = syn[2*k+1];
            for (int j = 0; j < COL_PAIRS; j++)
                r.bit_pos[j] = syn[COL_BASE+2*j+1];
        end else begin
            r.cls = ERR_FATAL;
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_line_acc.sv
module ecc_line_acc
    import ecc_pkg::*;
#(
    parameter int N_IDX = ecc_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             ce_i,
    input  logic             end_i,
    input  logic [N_IDX-1:0] idx_i,
    input  logic             par_i,
    output line_par_t        sum_o
);

    line_par_t        acc_q;
    logic [N_IDX-1:0] ev_n;
    logic [N_IDX-1:0] od_n;

    for (genvar k = 0; k < N_IDX; k++) begin : g_idx
        assign ev_n[k] = acc_q.even[k] ^ (par_i & ~idx_i[k]);
        assign od_n[k] = acc_q.odd[k]  ^ (par_i &  idx_i[k]);
    end

    assign sum_o = '{odd: od_n, even: ev_n};

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            acc_q <= '0;
        else if (ce_i)
            acc_q <= end_i ? line_par_t'('0) : sum_o;
    end

endmodule

// File: rtl/ecc_col_acc.sv
module ecc_col_acc
    import ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              ce_i,
    input  logic              end_i,
    input  logic [BYTE_W-1:0] data_i,
    output col_par_t          sum_o
);

    col_par_t acc_q;
    col_par_t step;

    always_comb begin
        step  = col_contrib(data_i);
        sum_o = acc_q ^ step;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            acc_q <= '0;
        else if (ce_i)
            acc_q <= end_i ? col_par_t'('0) : sum_o;
    end

endmodule

// File: rtl/ecc_compare.sv
module ecc_compare
    import ecc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic                 wide_i,
    input  logic [CODE_W-1:0]    stored_i,
    input  logic [CODE_W-1:0]    calc_i,
    output logic                 done_o,
    output cmp_result_t          res_o
);

    cmp_result_t res_n;

    always_comb res_n = classify(stored_i ^ calc_i, wide_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            res_o  <= '{cls: ERR_NONE, byte_idx: '0, bit_pos: '0};
        end else begin
            done_o <= req_i;
            if (req_i)
                res_o <= res_n;
        end
    end

endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
    import ecc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 mode_wide,
    input  logic                 in_valid,
    input  logic [BYTE_W-1:0]    in_data,
    output logic                 code_valid,
    output logic                 code_half,
    output logic [CODE_W-1:0]    code,
    input  logic                 cmp_req,
    input  logic                 cmp_wide,
    input  logic [CODE_W-1:0]    cmp_stored,
    input  logic [CODE_W-1:0]    cmp_calc,
    output logic                 cmp_done,
    output logic [1:0]           cmp_class,
    output logic [IDX_W-1:0]     cmp_byte,
    output logic [COL_PAIRS-1:0] cmp_bit
);

    localparam int NARROW_W = IDX_W - 1;

    logic [IDX_W-1:0] cnt_q;
    logic             accept;
    logic             last_byte;
    logic             page_end;
    logic [IDX_W-1:0] line_idx;
    line_par_t        line_sum;
    col_par_t         col_sum;
    cmp_result_t      cmp_res;

    assign accept    = in_valid & ~clr;
    assign last_byte = mode_wide ? (&cnt_q) : (&cnt_q[NARROW_W-1:0]);
    assign page_end  = accept & last_byte;
    assign line_idx  = mode_wide ? cnt_q : {1'b0, cnt_q[NARROW_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (accept)
            cnt_q <= cnt_q + 1'b1;
    end

    ecc_line_acc #(.N_IDX(IDX_W)) u_line (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr),
        .ce_i  (accept),
        .end_i (page_end),
        .idx_i (line_idx),
        .par_i (^in_data),
        .sum_o (line_sum)
    );

    ecc_col_acc u_col (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .ce_i   (accept),
        .end_i  (page_end),
        .data_i (in_data),
        .sum_o  (col_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_valid <= 1'b0;
            code_half  <= 1'b0;
            code       <= '1;
        end else begin
            code_valid <= page_end;
            if (page_end) begin
                code      <= pack_code(line_sum, col_sum, mode_wide);
                code_half <= ~mode_wide & cnt_q[NARROW_W];
            end
        end
    end

    ecc_compare u_cmp (
        .clk      (clk),
        .rst      (rst),
        .req_i    (cmp_req),
        .wide_i   (cmp_wide),
        .stored_i (cmp_stored),
        .calc_i   (cmp_calc),
        .done_o   (cmp_done),
        .res_o    (cmp_res)
    );

    assign cmp_class = cmp_res.cls;
    assign cmp_byte  = cmp_res.byte_idx;
    assign cmp_bit   = cmp_res.bit_pos;

endmodule

// File: rtl/ecc_stream_gen_chk.sv
module ecc_stream_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        clr,
    input logic        mode_wide,
    input logic        in_valid,
    input logic        code_valid,
    input logic        code_half,
    input logic [23:0] code,
    input logic        cmp_req,
    input logic        cmp_done,
    input logic [1:0]  cmp_class,
    input logic [8:0]  cmp_byte,
    input logic [2:0]  cmp_bit
);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid); // R11
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !code_valid |-> $stable(code)); // R11
    AST_NARROW_PAD: assert property (@(posedge clk) disable iff (rst)
        (code_valid && !$past(mode_wide)) |-> (code[17:16] == 2'b11)); // R2
    AST_WIDE_HALF: assert property (@(posedge clk) disable iff (rst)
        (code_valid && $past(mode_wide)) |-> !code_half); // R12
    AST_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(in_valid && !clr)); // R6
    AST_CMP_DONE: assert property (@(posedge clk) disable iff (rst)
        cmp_req |=> cmp_done); // R7
    AST_CMP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cmp_req |=> !cmp_done); // R7
    AST_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmp_done && cmp_class != 2'd1) |-> (cmp_byte == 9'd0 && cmp_bit == 3'd0)); // R8

endmodule

bind ecc_stream_gen ecc_stream_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .mode_wide  (mode_wide),
    .in_valid   (in_valid),
    .code_valid (code_valid),
    .code_half  (code_half),
    .code       (code),
    .cmp_req    (cmp_req),
    .cmp_done   (cmp_done),
    .cmp_class  (cmp_class),
    .cmp_byte   (cmp_byte),
    .cmp_bit    (cmp_bit)
);

// File: tb/ecc_stream_gen_test.sv
module ecc_stream_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        mode_wide = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        code_valid;
    logic        code_half;
    logic [23:0] code;
    logic        cmp_req = 1'b0;
    logic        cmp_wide = 1'b0;
    logic [23:0] cmp_stored = '0;
    logic [23:0] cmp_calc = '0;
    logic        cmp_done;
    logic [1:0]  cmp_class;
    logic [8:0]  cmp_byte;
    logic [2:0]  cmp_bit;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [23:0] code;
        logic        half;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [7:0] pg [512];

    always #5 clk = ~clk;

    ecc_stream_gen uut (.*);

    // Reference code from the layout in R4/R5.
    function automatic logic [23:0] model(int base, bit wide);
        logic [8:0]  le = '0, lo = '0;
        logic [2:0]  ce = '0, co = '0;
        logic [23:0] c = '1;
        int n = wide ? 512 : 256;
        int nk = wide ? 9 : 8;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = pg[base + i];
            for (int k = 0; k < nk; k++)
                if ((i >> k) & 1) lo[k] ^= ^d; else le[k] ^= ^d;
            for (int b = 0; b < 8; b++)
                for (int j = 0; j < 3; j++)
                    if ((b >> j) & 1) co[j] ^= d[b]; else ce[j] ^= d[b];
        end
        for (int k = 0; k < nk; k++) begin
            c[2*k] = le[k];
            c[2*k+1] = lo[k];
        end
        for (int j = 0; j < 3; j++) begin
            c[18+2*j] = ce[j];
            c[19+2*j] = co[j];
        end
        return c;
    endfunction

    task automatic fill(int seed);
        for (int i = 0; i < 512; i++)
            pg[i] = 8'((i * 37) + (seed * 11) + (i >> 3) + (i * i * seed));
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: stream n bytes from pg[base], optional idle bubbles with junk data.
    task automatic stream(int base, int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = ~pg[base + i] ^ 8'h5A;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pg[base + i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hC3;
    endtask

    task automatic push(logic [23:0] c, logic h, string tag);
        exp_t e;
        e.code = c;
        e.half = h;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_cmp(logic [23:0] st, logic [23:0] ca, bit wide,
                          logic [1:0] ecls, logic [8:0] ebyte, logic [2:0] ebit, string req);
        @(negedge clk);
        cmp_req = 1'b1;
        cmp_wide = wide;
        cmp_stored = st;
        cmp_calc = ca;
        @(negedge clk);
        cmp_req = 1'b0;
        check(cmp_done == 1'b1, req, "cmp_done", 32'(cmp_done), 32'd1);
        check(cmp_class == ecls, req, "cmp_class", 32'(cmp_class), 32'(ecls));
        check(cmp_byte == ebyte && cmp_bit == ebit, req, "cmp_byte/bit",
              {20'd0, cmp_byte, cmp_bit}, {20'd0, ebyte, ebit});
    endtask

    // Monitor: pops expectations as codes appear; also checks pulse width (R11).
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_valid && code_valid)
                check(1'b0, "R11", "code_valid longer than one cycle", 32'd1, 32'd0);
            if (code_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1/R3", "unexpected code_valid", {8'd0, code}, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(code == e.code && code_half == e.half, e.tag, "code/half",
                          {7'd0, code_half, code}, {7'd0, e.half, e.code});
                end
            end
        end
        prev_valid = code_valid;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] c_clean, c_bad, c_two;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(code_valid == 0 && cmp_done == 0, "R1", "valid flags after reset",
              {30'd0, code_valid, cmp_done}, 32'd0);
        check(code == 24'hFFFFFF, "R1", "code after reset", {8'd0, code}, 32'h00FFFFFF);

        // R2, R4, R5, R12: narrow mode, two codes over 512 bytes
        fill(1);
        mode_wide = 1'b0;
        push(model(0, 0), 1'b0, "R2/R4/R5 first half");
        push(model(256, 0), 1'b1, "R2/R12 second half");
        stream(0, 512, 0);
        drain();

        // R3, R6: wide mode with idle bubbles carrying junk
        fill(2);
        mode_wide = 1'b1;
        push(model(0, 1), 1'b0, "R3/R6/R12 wide page");
        stream(0, 512, 1);
        drain();

        // R1: clear discards partial page
        fill(3);
        mode_wide = 1'b0;
        stream(0, 100, 0);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        fill(4);
        push(model(0, 0), 1'b0, "R1 after clear");
        stream(0, 256, 1);
        drain();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;

        // R11: code held between pulses
        c_clean = code;
        repeat (5) @(negedge clk);
        check(code == c_clean, "R11", "code held", {8'd0, code}, {8'd0, c_clean});
        check(exp_q.size() == 0, "R2/R3", "missing code pulses", 32'(exp_q.size()), 32'd0);

        // R7: equal codes
        fill(5);
        do_cmp(model(0, 1), model(0, 1), 1, 2'd0, 9'd0, 3'd0, "R7");

        // R8: single flip in wide page, also streamed through the design
        c_clean = model(0, 1);
        pg[300][5] = ~pg[300][5];
        c_bad = model(0, 1);
        mode_wide = 1'b1;
        push(c_bad, 1'b0, "R8 corrupted wide page");
        stream(0, 512, 0);
        drain();
        do_cmp(c_clean, code, 1, 2'd1, 9'd300, 3'd5, "R8 wide byte 300 bit 5");
        // R10: second flip makes it uncorrectable
        pg[17][0] = ~pg[17][0];
        c_two = model(0, 1);
        do_cmp(c_clean, c_two, 1, 2'd3, 9'd0, 3'd0, "R10 double flip");
        pg[17][0] = ~pg[17][0];
        pg[300][5] = ~pg[300][5];

        // R8: wide boundary byte 511 bit 0
        pg[511][0] = ~pg[511][0];
        do_cmp(c_clean, model(0, 1), 1, 2'd1, 9'd511, 3'd0, "R8 wide byte 511 bit 0");
        pg[511][0] = ~pg[511][0];

        // R8: narrow pages, byte 77 bit 2 and edges
        c_clean = model(0, 0);
        pg[77][2] = ~pg[77][2];
        do_cmp(c_clean, model(0, 0), 0, 2'd1, 9'd77, 3'd2, "R8 narrow byte 77 bit 2");
        pg[77][2] = ~pg[77][2];
        pg[255][7] = ~pg[255][7];
        do_cmp(c_clean, model(0, 0), 0, 2'd1, 9'd255, 3'd7, "R8 narrow byte 255 bit 7");
        pg[255][7] = ~pg[255][7];
        pg[0][0] = ~pg[0][0];
        do_cmp(c_clean, model(0, 0), 0, 2'd1, 9'd0, 3'd0, "R8 narrow byte 0 bit 0");
        pg[0][0] = ~pg[0][0];

        // R9: single bit in the code itself
        do_cmp(c_clean ^ 24'h080000, c_clean, 0, 2'd2, 9'd0, 3'd0, "R9 code bit 19");
        do_cmp(c_clean, c_clean ^ 24'h000001, 1, 2'd2, 9'd0, 3'd0, "R9 code bit 0");

        // R10: narrow pad pair disturbed, and two-byte flip in narrow mode
        do_cmp(c_clean ^ 24'h030000, c_clean, 0, 2'd3, 9'd0, 3'd0, "R10 pad pair");
        pg[10][1] = ~pg[10][1];
        pg[200][6] = ~pg[200][6];
        do_cmp(c_clean, model(0, 0), 0, 2'd3, 9'd0, 3'd0, "R10 narrow double");

        drain();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule